// File: doc/BRIEF.md
# CCD Vertical Readout Sequencer

This block is the vertical timing controller for a progressive-scan interline image sensor. On each frame-start request it takes the readout mode and the clock-rate select and plays out the frame's vertical actions as one-cycle strobes. First it fires the readout-gate pulses. Next it sweeps away the unwanted top rows with high-speed transfer, then runs one line period per output line. It closes with a bottom sweep and a frame-done strobe. Analog clock levels, horizontal pixel clocking, shuttering and exposure sit outside the block. They see only these strobes.

Line decimation is done at the sensor, not by skipping output lines. The readout gates belong to three groups, and each group serves fixed line positions inside every 8-line group. A mode reads a subset of lines by pulsing only the groups that serve them. The addition modes take two gate steps, with a short register shift between them. Same-colour charges from two lines are therefore summed inside the vertical register. Windowed (center and focus) modes keep a region centered in the 1236-row effective area and sweep the rest.

Top module: `ccd_vseq`

## Requirements
- R1: After reset, and whenever no frame is running, every strobe output is low. A frame starts only on a cycle where `frame_go` is high while idle.
- R2: `gate_pulse` bit 0 is group A, which serves lines 1 and 6 of each 8-line group. Bit 1 is group B, for lines 2 and 5. Bit 2 is group C, for lines 3, 4, 7 and 8. The first cycle of a frame pulses the groups that the mode reads. Full reads pulse 3'b111, 2-of-8 reads pulse 3'b001 and 2-of-4 reads pulse 3'b100.
- R3: Addition modes pulse group C first (3'b100) and then give exactly ADD_SHIFTS (default 2) shift strobes. They then pulse groups A and B together (3'b011) on the next cycle.
- R4: `mode_sel` codes map to read methods as follows. 0 is full, 1 is 2-of-8, 2 is 2-of-4 and 3 is addition. 4 is center 2-of-4, 5 is center addition and 6 is center full. 7 and 8 are the wide and narrow focus windows with 2-of-8.
- R5: The output line count is 1220 for mode 0, 305 for mode 1, and 610 for modes 2 and 3. For `rate_hi`=0/1 the counts are 434/568 for modes 4 and 5, 444/580 for mode 6, 170/235 for mode 7 and 43/75 for mode 8.
- R6: Modes 0 to 3 make no sweep. In windowed modes the kept rows are the line count times the rows per line (1 for full, 2 for 2-of-4 and addition, 4 for 2-of-8). The top sweep is floor((1236 - kept)/2) strobes and the bottom sweep is the remaining rows.
- R7: Each output line is one `shift_stb` cycle followed directly by one `line_vld` cycle. The first line starts right after the top sweep. The total shift strobes equal the line count plus, in addition modes, ADD_SHIFTS.
- R8: `frame_done` is a single cycle. It falls on cycle G + T + 2L + B + 1 of the frame, where G is 1, or 2 + ADD_SHIFTS in addition modes. T and B are the sweep counts and L is the line count. The block is idle on the next cycle.
- R9: Mode and rate are sampled only at frame start. Changes during a frame, and `frame_go` pulses during a frame, have no effect on that frame.
- R10: Reserved mode codes 9 to 15 behave as mode 0.
- R11: At most one strobe output (any gate bit counting as one) is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Frame-start request, accepted when idle |
| mode_sel | input | 4 | Readout mode code |
| rate_hi | input | 1 | 1 selects the faster-clock line-count table |
| gate_pulse | output | 3 | Readout-gate group pulses {C,B,A} |
| shift_stb | output | 1 | Shift the vertical register by one line |
| sweep_stb | output | 1 | One high-speed sweep transfer |
| line_vld | output | 1 | One line-output period |
| frame_done | output | 1 | Frame complete |

## Verification
The frame's cycle 1 is the first cycle after the edge that samples `frame_go`. Every result is due at a fixed offset from that edge. The gate pulse comes on cycle 1, the addition-mode shifts on cycles 2 and 3, and the second gate step on cycle 4. The sweep and line counts are known from the mode, and the done strobe lands on cycle G + T + 2L + B + 1. The bench starts counting at the first falling edge after the sampling edge and reads the outputs on falling edges. It sweeps all nine modes at both rates and compares every cycle offset with values derived from the line tables.

// File: rtl/ccdv_pkg.sv
package ccdv_pkg;

   typedef enum logic [1:0] {
      RD_FULL = 2'd0,
      RD_2OF8 = 2'd1,
      RD_2OF4 = 2'd2,
      RD_ADD  = 2'd3
   } rdmeth_t;

   typedef enum logic [3:0] {
      S_IDLE  = 4'd0,
      S_GATE1 = 4'd1,
      S_ASHF  = 4'd2,
      S_GATE2 = 4'd3,
      S_TOP   = 4'd4,
      S_LSH   = 4'd5,
      S_LVAL  = 4'd6,
      S_BOT   = 4'd7,
      S_DONE  = 4'd8
   } vstate_t;

   typedef struct packed {
      rdmeth_t meth;
      logic    windowed;
   } mode_attr_t;

   localparam int NUM_MODES = 9;
   localparam int GROUP_LINES = 8;

   function automatic mode_attr_t attr_of(int m);
      mode_attr_t a;
      case (m)
         1:       a = '{meth: RD_2OF8, windowed: 1'b0};
         2:       a = '{meth: RD_2OF4, windowed: 1'b0};
         3:       a = '{meth: RD_ADD,  windowed: 1'b0};
         4:       a = '{meth: RD_2OF4, windowed: 1'b1};
         5:       a = '{meth: RD_ADD,  windowed: 1'b1};
         6:       a = '{meth: RD_FULL, windowed: 1'b1};
         7, 8:    a = '{meth: RD_2OF8, windowed: 1'b1};
         default: a = '{meth: RD_FULL, windowed: 1'b0};
      endcase
      return a;
   endfunction

   function automatic int rows_per_line(rdmeth_t m);
      case (m)
         RD_2OF8: return 4;
         RD_2OF4: return 2;
         RD_ADD:  return 2;
         default: return 1;
      endcase
   endfunction

   // gate group serving line position ln (0-based) of an 8-line group
   function automatic logic [2:0] group_of_line(int ln);
      case (ln)
         0, 5:    return 3'b001;
         1, 4:    return 3'b010;
         default: return 3'b100;
      endcase
   endfunction

   // line positions read by a method; step2 is the second addition step
   function automatic logic [GROUP_LINES-1:0] lines_read(rdmeth_t m, logic step2);
      case (m)
         RD_2OF8: return 8'b0010_0001;
         RD_2OF4: return 8'b1100_1100;
         RD_ADD:  return step2 ? 8'b0011_0011 : 8'b1100_1100;
         default: return 8'b1111_1111;
      endcase
   endfunction

   function automatic logic [2:0] gates_for(rdmeth_t m, logic step2);
      logic [2:0] g;
      logic [GROUP_LINES-1:0] rd;
      g  = 3'b000;
      rd = lines_read(m, step2);
      for (int i = 0; i < GROUP_LINES; i++) begin
         if (rd[i]) g = g | group_of_line(i);
      end
      return g;
   endfunction

endpackage

// File: rtl/ccdv_mode_map.sv
module ccdv_mode_map
   import ccdv_pkg::*;
#(
   parameter int CW         = 11,
   parameter int EFF_ROWS   = 1236,
   parameter int ACT_ROWS   = 1220,
   parameter int L_CTR_SLOW = 434,
   parameter int L_CTR_FAST = 568,
   parameter int L_C3_SLOW  = 444,
   parameter int L_C3_FAST  = 580,
   parameter int L_AF1_SLOW = 170,
   parameter int L_AF1_FAST = 235,
   parameter int L_AF2_SLOW = 43,
   parameter int L_AF2_FAST = 75
) (
   input  logic [3:0]    mode_code,
   input  logic          rate_hi,
   output rdmeth_t       meth,
   output logic [CW-1:0] n_lines,
   output logic [CW-1:0] n_top,
   output logic [CW-1:0] n_bot
);

   localparam int ENTRIES = 2 * NUM_MODES;

   function automatic int lines_for(int m, int hi);
      case (m)
         1:       return ACT_ROWS / 4;
         2, 3:    return ACT_ROWS / 2;
         4, 5:    return (hi != 0) ? L_CTR_FAST : L_CTR_SLOW;
         6:       return (hi != 0) ? L_C3_FAST  : L_C3_SLOW;
         7:       return (hi != 0) ? L_AF1_FAST : L_AF1_SLOW;
         8:       return (hi != 0) ? L_AF2_FAST : L_AF2_SLOW;
         default: return ACT_ROWS;
      endcase
   endfunction

   rdmeth_t       tab_meth  [ENTRIES];
   logic [CW-1:0] tab_lines [ENTRIES];
   logic [CW-1:0] tab_top   [ENTRIES];
   logic [CW-1:0] tab_bot   [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam mode_attr_t ATTR = attr_of(i / 2);
      localparam int LN   = lines_for(i / 2, i % 2);
      localparam int KEPT = LN * rows_per_line(ATTR.meth);
      localparam int TOP  = ATTR.windowed ? (EFF_ROWS - KEPT) / 2 : 0;
      localparam int BOT  = ATTR.windowed ? (EFF_ROWS - KEPT - TOP) : 0;
      if (LN < 1 || KEPT > EFF_ROWS || LN >= (1 << CW)) begin : g_bad
         $error("ccdv_mode_map: entry %0d does not fit the effective area", i);
      end
      assign tab_meth[i]  = ATTR.meth;
      assign tab_lines[i] = CW'(LN);
      assign tab_top[i]   = CW'(TOP);
      assign tab_bot[i]   = CW'(BOT);
   end

   logic [3:0] mode_eff;
   logic [4:0] idx;

   assign mode_eff = (mode_code < 4'(NUM_MODES)) ? mode_code : 4'd0;
   assign idx      = {mode_eff, rate_hi};

   assign meth    = tab_meth[idx];
   assign n_lines = tab_lines[idx];
   assign n_top   = tab_top[idx];
   assign n_bot   = tab_bot[idx];

endmodule

// File: rtl/ccdv_downcnt.sv
module ccdv_downcnt #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] value;

   if (W < 2) begin : g_bad_w
      $error("ccdv_downcnt: width too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= '0;
      else if (load) value <= load_val;
      else if (dec)  value <= value - 1'b1;
   end

   assign zero = (value == '0);

endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
   import ccdv_pkg::*;
#(
   parameter int CW         = 11,
   parameter int EFF_ROWS   = 1236,
   parameter int ACT_ROWS   = 1220,
   parameter int ADD_SHIFTS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_go,
   input  logic [3:0] mode_sel,
   input  logic       rate_hi,
   output logic [2:0] gate_pulse,
   output logic       shift_stb,
   output logic       sweep_stb,
   output logic       line_vld,
   output logic       frame_done
);

   localparam int MIN_CW = $clog2(EFF_ROWS + 1);

   if (CW < MIN_CW || ADD_SHIFTS < 1 || ADD_SHIFTS >= (1 << CW) || ACT_ROWS > EFF_ROWS) begin : g_bad_cfg
      $error("ccd_vseq: inconsistent configuration");
   end

   rdmeth_t       map_meth, lat_meth;
   logic [CW-1:0] map_lines, map_top, map_bot;
   logic [CW-1:0] lat_lines, lat_top, lat_bot;

   ccdv_mode_map #(
      .CW(CW), .EFF_ROWS(EFF_ROWS), .ACT_ROWS(ACT_ROWS)
   ) u_map (
      .mode_code(mode_sel),
      .rate_hi  (rate_hi),
      .meth     (map_meth),
      .n_lines  (map_lines),
      .n_top    (map_top),
      .n_bot    (map_bot)
   );

   vstate_t       st, st_nx;
   logic          cnt_ld, cnt_dec, cnt_zero;
   logic [CW-1:0] cnt_val;
   vstate_t       body_st, tail_st;
   logic [CW-1:0] body_val, tail_val;

   ccdv_downcnt #(.W(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_ld),
      .load_val(cnt_val),
      .dec     (cnt_dec),
      .zero    (cnt_zero)
   );

   // mode profile captured only on an accepted frame start
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_meth  <= RD_FULL;
         lat_lines <= '0;
         lat_top   <= '0;
         lat_bot   <= '0;
      end else if (st == S_IDLE && frame_go) begin
         lat_meth  <= map_meth;
         lat_lines <= map_lines;
         lat_top   <= map_top;
         lat_bot   <= map_bot;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= S_IDLE;
      else        st <= st_nx;
   end

   assign body_st  = (lat_top != '0) ? S_TOP : S_LSH;
   assign body_val = (lat_top != '0) ? lat_top - 1'b1 : lat_lines - 1'b1;
   assign tail_st  = (lat_bot != '0) ? S_BOT : S_DONE;
   assign tail_val = lat_bot - 1'b1;

   always_comb begin
      st_nx   = st;
      cnt_ld  = 1'b0;
      cnt_val = '0;
      cnt_dec = 1'b0;
      case (st)
         S_IDLE: if (frame_go) st_nx = S_GATE1;
         S_GATE1: begin
            cnt_ld = 1'b1;
            if (lat_meth == RD_ADD) begin
               st_nx   = S_ASHF;
               cnt_val = CW'(ADD_SHIFTS - 1);
            end else begin
               st_nx   = body_st;
               cnt_val = body_val;
            end
         end
         S_ASHF: begin
            if (cnt_zero) st_nx = S_GATE2;
            else          cnt_dec = 1'b1;
         end
         S_GATE2: begin
            st_nx   = body_st;
            cnt_ld  = 1'b1;
            cnt_val = body_val;
         end
         S_TOP: begin
            if (cnt_zero) begin
               st_nx   = S_LSH;
               cnt_ld  = 1'b1;
               cnt_val = lat_lines - 1'b1;
            end else begin
               cnt_dec = 1'b1;
            end
         end
         S_LSH: st_nx = S_LVAL;
         S_LVAL: begin
            if (cnt_zero) begin
               st_nx   = tail_st;
               cnt_ld  = 1'b1;
               cnt_val = tail_val;
            end else begin
               st_nx   = S_LSH;
               cnt_dec = 1'b1;
            end
         end
         S_BOT: begin
            if (cnt_zero) st_nx = S_DONE;
            else          cnt_dec = 1'b1;
         end
         S_DONE:  st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_comb begin
      case (st)
         S_GATE1: gate_pulse = gates_for(lat_meth, 1'b0);
         S_GATE2: gate_pulse = gates_for(RD_ADD, 1'b1);
         default: gate_pulse = 3'b000;
      endcase
   end

   assign shift_stb  = (st == S_ASHF) || (st == S_LSH);
   assign sweep_stb  = (st == S_TOP) || (st == S_BOT);
   assign line_vld   = (st == S_LVAL);
   assign frame_done = (st == S_DONE);

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|gate_pulse, shift_stb, sweep_stb, line_vld, frame_done}));

   // R7
   vld_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_vld |-> $past(shift_stb));

   // R8
   done_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (gate_pulse == 3'b000 && !shift_stb && !sweep_stb && !line_vld && !frame_done));

   // R3
   add_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_pulse == 3'b011) |-> $past(shift_stb));

   // R2
   first_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_pulse != 3'b000 && gate_pulse != 3'b011) |-> $past(frame_go));

   // R9
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE) |=> ($stable(lat_lines) && $stable(lat_meth) && $stable(lat_top)));

endmodule

// File: tb/ccd_vseq_tb.sv
`timescale 1ns/1ps
module ccd_vseq_tb;

   localparam int EFF = 1236;
   localparam int ACT = 1220;
   localparam int ASH = 2;
   localparam int WATCHDOG = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_go = 1'b0;
   logic [3:0] mode_sel = 4'd0;
   logic       rate_hi = 1'b0;
   logic [2:0] gate_pulse;
   logic       shift_stb, sweep_stb, line_vld, frame_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ccd_vseq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_go  (frame_go),
      .mode_sel  (mode_sel),
      .rate_hi   (rate_hi),
      .gate_pulse(gate_pulse),
      .shift_stb (shift_stb),
      .sweep_stb (sweep_stb),
      .line_vld  (line_vld),
      .frame_done(frame_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // method: 0 full, 1 2-of-8, 2 2-of-4, 3 addition (R4, R10)
   function automatic int meth_of(int m);
      case (m)
         1, 7, 8: return 1;
         2, 4:    return 2;
         3, 5:    return 3;
         default: return 0;
      endcase
   endfunction

   function automatic int lines_of(int m, int hi);
      case (m)
         1:       return ACT / 4;
         2, 3:    return ACT / 2;
         4, 5:    return hi ? 568 : 434;
         6:       return hi ? 580 : 444;
         7:       return hi ? 235 : 170;
         8:       return hi ? 75 : 43;
         default: return ACT;
      endcase
   endfunction

   function automatic int rpl(int m);
      case (meth_of(m))
         1:       return 4;
         2, 3:    return 2;
         default: return 1;
      endcase
   endfunction

   function automatic int top_of(int m, int hi);
      if (m < 4 || m > 8) return 0;
      return (EFF - lines_of(m, hi) * rpl(m)) / 2;
   endfunction

   function automatic int bot_of(int m, int hi);
      if (m < 4 || m > 8) return 0;
      return EFF - lines_of(m, hi) * rpl(m) - top_of(m, hi);
   endfunction

   function automatic int gate1_of(int m);
      case (meth_of(m))
         1:       return 1;
         2, 3:    return 4;
         default: return 7;
      endcase
   endfunction

   function automatic bit quiet();
      return gate_pulse == 3'b000 && !shift_stb && !sweep_stb && !line_vld && !frame_done;
   endfunction

   task automatic run_frame(input int m, input bit hi, input bit busy_go, input int chg);
      int cyc, g1, g2, top_n, bot_n, nl, nsh, bad_order, multi, done_cyc, exp_tot, quiet_bad;
      bit prev_sh, is_add, add_sh_ok;
      cyc = 0; g1 = 0; g2 = 0; top_n = 0; bot_n = 0; nl = 0; nsh = 0;
      bad_order = 0; multi = 0; done_cyc = -1; quiet_bad = 0;
      prev_sh = 1'b0; add_sh_ok = 1'b1;
      is_add = (meth_of(m) == 3);
      @(negedge clk);
      mode_sel = 4'(m); rate_hi = hi; frame_go = 1'b1;
      @(negedge clk);
      frame_go = 1'b0;
      if (chg >= 0) begin
         mode_sel = 4'(chg);
         rate_hi  = ~hi;
      end
      while (done_cyc < 0 && cyc < 10000) begin
         cyc++;
         if (busy_go) frame_go = (cyc == 2);
         if (cyc == 1) g1 = int'(gate_pulse);
         if (is_add && (cyc == 2 || cyc == 3) && !(shift_stb && gate_pulse == 3'b000)) add_sh_ok = 1'b0;
         if (is_add && cyc == 4) g2 = int'(gate_pulse);
         if (sweep_stb) begin
            if (nl == 0) top_n++;
            else         bot_n++;
         end
         if (shift_stb) nsh++;
         if (line_vld) begin
            nl++;
            if (!prev_sh) bad_order++;
         end
         if ((int'(|gate_pulse) + int'(shift_stb) + int'(sweep_stb) + int'(line_vld) + int'(frame_done)) > 1) multi++;
         if (frame_done) done_cyc = cyc;
         prev_sh = shift_stb;
         @(negedge clk);
      end
      frame_go = 1'b0;
      for (int k = 0; k < 3; k++) begin
         if (!quiet()) quiet_bad++;
         @(negedge clk);
      end
      exp_tot = (is_add ? 2 + ASH : 1) + top_of(m, hi) + 2 * lines_of(m, hi) + bot_of(m, hi) + 1;
      check(g1 == gate1_of(m), "R2/R4/R10 first gate pattern", g1, gate1_of(m));
      if (is_add) begin
         check(add_sh_ok, "R3 shifts between addition steps", int'(add_sh_ok), 1);
         check(g2 == 3, "R3 second addition gate", g2, 3);
      end
      check(nl == lines_of(m, hi), "R5 output line count", nl, lines_of(m, hi));
      check(top_n == top_of(m, hi), "R6 top sweep count", top_n, top_of(m, hi));
      check(bot_n == bot_of(m, hi), "R6 bottom sweep count", bot_n, bot_of(m, hi));
      check(nsh == lines_of(m, hi) + (is_add ? ASH : 0), "R7 shift strobe count", nsh,
            lines_of(m, hi) + (is_add ? ASH : 0));
      check(bad_order == 0, "R7 line valid follows shift", bad_order, 0);
      check(multi == 0, "R11 exclusive strobes", multi, 0);
      check(done_cyc == exp_tot, "R8 frame done cycle", done_cyc, exp_tot);
      check(quiet_bad == 0, "R8/R9 idle after done", quiet_bad, 0);
   endtask

   initial begin
      #(WATCHDOG * 4);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int qb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      qb = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (!quiet()) qb++;
      end
      check(qb == 0, "R1 idle after reset", qb, 0);
      for (int m = 0; m < 9; m++) begin
         for (int hi = 0; hi < 2; hi++) begin
            run_frame(m, hi[0], 1'b0, -1);
         end
      end
      // R10 reserved code
      run_frame(13, 1'b1, 1'b0, -1);
      // R9 mode change and restart request during a frame
      run_frame(7, 1'b1, 1'b1, 0);
      run_frame(2, 1'b0, 1'b0, -1);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule